// File: doc/BRIEF.md
# Interrupt Dispatch and Halt Sequencer

This block runs ahead of every instruction fetch of an 8-bit processor with a 16-bit address space. A step request from the core asks it what happens next. If the core is halted and nothing is pending, it spends one idle machine cycle. If an enabled request is pending and interrupts are on, it runs the full entry sequence: two idle cycles, acknowledgement of the serviced source, a two-byte push of the return address, one settling cycle and a jump to the handler. Otherwise it grants the fetch.

The block owns three pieces of state. The halted flag is set by a completed halt instruction. It is cleared by any enabled pending request, whether or not interrupts are on. The halt-bug flag either makes the next fetch leave the program counter where it was, or makes the next interrupt entry push the program counter minus one. The master interrupt enable follows a three-state scheme, so that an enable instruction takes effect only after the instruction after it completes. Every machine cycle the block spends is marked on `mcycle`.

Top module: `irq_front`

## Requirements
- R1: After reset the block is idle: `halted`, `ime`, `mcycle`, `step_done`, `fetch_go`, `mem_we`, `pc_load` are all 0 and `ack_clear` is 0.
- R2: A step while halted with no source both requested and enabled yields exactly one cycle with `mcycle`=1 and `step_done`=1. `fetch_go` stays 0 and `halted` stays 1.
- R3: A step while halted with at least one source both requested and enabled clears `halted`. If `ime` is 0, the next cycle has `fetch_go`=1 and `step_done`=1.
- R4: A step with `ime`=1 and an active source starts the entry sequence. The first two cycles have `mcycle`=1, `mem_we`=0 and `ack_clear`=0. In the third cycle `ack_clear` is one-hot on the serviced source and `ime` reads 0.
- R5: In entry cycle 3, the block writes the high byte of the return address to SP-1. In cycle 4 it writes the low byte to SP-2. `sp_out` carries the same address with `sp_load`=1, and addresses wrap modulo 2^16.
- R6: In entry cycle 5, `mcycle`=1, `mem_we`=0, `pc_load`=1, `step_done`=1 and `pc_out` = 0x0040 + 8*k, where k is the serviced source index.
- R7: The serviced source is the lowest-numbered bit set in `irq_req & irq_en`. A requested source whose enable bit is 0 is ignored for wake-up and for dispatch.
- R8: If the halt-bug flag is set when an entry starts, the pushed return address is `pc_in`-1 and the flag is cleared. A later entry pushes `pc_in`.
- R9: If the halt-bug flag is set when a fetch is granted, `fetch_keep_pc`=1 in the `fetch_go` cycle and the flag is cleared. The next granted fetch has `fetch_keep_pc`=0.
- R10: A completed enable instruction (`instr_done` with `op_ei`) leaves `ime` at 0. `ime` becomes 1 after the next completed instruction, and an entry is not taken in between. If `ime` is already 1, it stays 1.
- R11: A completed disable instruction sets `ime` to 0 in the following cycle, and this cancels a pending enable. A completed return-from-interrupt sets `ime` to 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine cycle per period |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Request to decide the next action, accepted while idle |
| instr_done | input | 1 | Pulse when an instruction completes |
| op_ei | input | 1 | Completed instruction was an interrupt enable |
| op_di | input | 1 | Completed instruction was an interrupt disable |
| op_reti | input | 1 | Completed instruction was a return from interrupt |
| op_halt | input | 1 | Completed instruction was a halt |
| halt_bug_set | input | 1 | Pulse that arms the halt-bug flag |
| irq_req | input | 5 | Pending request bits |
| irq_en | input | 5 | Enable mask bits |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 16 | Current stack pointer |
| mcycle | output | 1 | A machine cycle spent by this block |
| step_done | output | 1 | Last cycle of the step's action |
| fetch_go | output | 1 | Fetch granted this cycle |
| fetch_keep_pc | output | 1 | Granted fetch must not advance the program counter |
| halted | output | 1 | Halted state |
| ime | output | 1 | Master interrupt enable in effect |
| ack_clear | output | 5 | One-hot clear of the serviced request bit |
| mem_we | output | 1 | Byte write strobe |
| mem_addr | output | 16 | Byte write address |
| mem_wdata | output | 8 | Byte write data |
| sp_load | output | 1 | Load the stack pointer from sp_out |
| sp_out | output | 16 | New stack pointer |
| pc_load | output | 1 | Load the program counter from pc_out |
| pc_out | output | 16 | Handler address |

## Verification
The entry sequence is swept over all 31 non-zero request patterns with every source enabled, and over all 31 non-zero enable masks with every source requesting. The first sweep checks that the lowest set bit wins. The second checks that masked sources never win, even when a higher-numbered source is present. The stack pointer and program counter vary with the pattern, and one case starts the stack at zero to expose address wrap. Separate directed patterns tell the halted-idle, wake-to-fetch and wake-to-dispatch paths apart. Others show the halt-bug flag acting on exactly one fetch or one entry, and the enable taking effect one instruction late.

// File: rtl/irq_front_pkg.sv
package irq_front_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 2 * BYTE_W;
    localparam int NUM_SRC  = 5;
    localparam int VEC_BASE = 'h40;
    localparam int VEC_STEP = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        IME_OFF,
        IME_ARMED,
        IME_ON
    } ime_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_HOLD,
        SQ_FETCH,
        SQ_WAIT1,
        SQ_WAIT2,
        SQ_PUSH_HI,
        SQ_PUSH_LO,
        SQ_SETTLE
    } seq_e;

    function automatic addr_t vec_addr(input int idx);
        return addr_t'(VEC_BASE + VEC_STEP * idx);
    endfunction

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/irq_front_pick.sv
module irq_front_pick
    import irq_front_pkg::*;
#(
    parameter int N     = NUM_SRC,
    parameter int IDX_W = idx_width(N)
) (
    input  logic [N-1:0]     req,
    input  logic [N-1:0]     en,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    logic [N-1:0] act;
    logic [N-1:0] grant;
    logic [N:0]   seen;

    assign act     = req & en;
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant[i]  = act[i] & ~seen[i];
        assign seen[i+1] = seen[i] | act[i];
    end

    assign any = seen[N];

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = idx | IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_front_ime.sv
module irq_front_ime
    import irq_front_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic instr_done,
    input  logic op_ei,
    input  logic op_di,
    input  logic op_reti,
    input  logic svc_clr,
    output logic ime_on
);
    ime_e cur, nxt;

    always_comb begin
        nxt = cur;
        if (svc_clr) begin
            nxt = IME_OFF;
        end else if (instr_done) begin
            if (op_di)
                nxt = IME_OFF;
            else if (op_reti)
                nxt = IME_ON;
            else if (op_ei)
                nxt = (cur == IME_ON) ? IME_ON : IME_ARMED;
            else if (cur == IME_ARMED)
                nxt = IME_ON;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= IME_OFF;
        else     cur <= nxt;
    end

    assign ime_on = (cur == IME_ON);
endmodule

// File: rtl/irq_front_seq.sv
module irq_front_seq
    import irq_front_pkg::*;
#(
    parameter int N     = NUM_SRC,
    parameter int IDX_W = idx_width(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             halt_set,
    input  logic             bug_set,
    input  logic             active_any,
    input  logic [IDX_W-1:0] pick_idx,
    input  logic             ime_on,
    input  addr_t            pc_in,
    input  addr_t            sp_in,
    output logic             svc_clr,
    output logic             mcycle,
    output logic             step_done,
    output logic             fetch_go,
    output logic             fetch_keep_pc,
    output logic             halted,
    output logic [N-1:0]     ack_clear,
    output logic             mem_we,
    output addr_t            mem_addr,
    output byte_t            mem_wdata,
    output logic             sp_load,
    output addr_t            sp_out,
    output logic             pc_load,
    output addr_t            pc_out
);
    typedef struct packed {
        addr_t            ret;
        addr_t            sp;
        logic [IDX_W-1:0] idx;
    } entry_t;

    seq_e   st, st_nxt;
    entry_t ent;
    logic   bug_q;
    logic   keep_q;
    logic   go_hold, go_svc, go_fetch;
    addr_t  push_addr;

    assign go_hold  = (st == SQ_IDLE) && step && halted && !active_any;
    assign go_svc   = (st == SQ_IDLE) && step && !go_hold && active_any && ime_on;
    assign go_fetch = (st == SQ_IDLE) && step && !go_hold && !go_svc;

    always_comb begin
        st_nxt = st;
        unique case (st)
            SQ_IDLE: begin
                if (go_hold)       st_nxt = SQ_HOLD;
                else if (go_svc)   st_nxt = SQ_WAIT1;
                else if (go_fetch) st_nxt = SQ_FETCH;
            end
            SQ_WAIT1:   st_nxt = SQ_WAIT2;
            SQ_WAIT2:   st_nxt = SQ_PUSH_HI;
            SQ_PUSH_HI: st_nxt = SQ_PUSH_LO;
            SQ_PUSH_LO: st_nxt = SQ_SETTLE;
            default:    st_nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= SQ_IDLE;
        else     st <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst)
            halted <= 1'b0;
        else if ((st == SQ_IDLE) && step && halted && active_any)
            halted <= 1'b0;
        else if (halt_set)
            halted <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            bug_q <= 1'b0;
        else if (go_svc || go_fetch)
            bug_q <= 1'b0;
        else if (bug_set)
            bug_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            keep_q <= 1'b0;
        else if (go_fetch)
            keep_q <= bug_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent <= '0;
        end else if (go_svc) begin
            ent.ret <= bug_q ? (pc_in - addr_t'(1)) : pc_in;
            ent.sp  <= sp_in;
            ent.idx <= pick_idx;
        end
    end

    assign push_addr = (st == SQ_PUSH_HI) ? (ent.sp - addr_t'(1)) : (ent.sp - addr_t'(2));

    always_comb begin
        mcycle = 1'b0;
        unique case (st)
            SQ_HOLD, SQ_WAIT1, SQ_WAIT2, SQ_PUSH_HI, SQ_PUSH_LO, SQ_SETTLE: mcycle = 1'b1;
            default: mcycle = 1'b0;
        endcase
    end

    assign step_done     = (st == SQ_HOLD) || (st == SQ_FETCH) || (st == SQ_SETTLE);
    assign fetch_go      = (st == SQ_FETCH);
    assign fetch_keep_pc = (st == SQ_FETCH) && keep_q;
    assign svc_clr       = (st == SQ_WAIT2);
    assign mem_we        = (st == SQ_PUSH_HI) || (st == SQ_PUSH_LO);
    assign mem_addr      = mem_we ? push_addr : '0;
    assign mem_wdata     = (st == SQ_PUSH_HI) ? ent.ret[ADDR_W-1:BYTE_W]
                         : (st == SQ_PUSH_LO) ? ent.ret[BYTE_W-1:0] : '0;
    assign sp_load       = mem_we;
    assign sp_out        = mem_addr;
    assign ack_clear     = (st == SQ_PUSH_HI) ? (N'(1) << ent.idx) : '0;
    assign pc_load       = (st == SQ_SETTLE);
    assign pc_out        = pc_load ? vec_addr(int'(ent.idx)) : '0;
endmodule

// File: rtl/irq_front.sv
module irq_front
    import irq_front_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              instr_done,
    input  logic              op_ei,
    input  logic              op_di,
    input  logic              op_reti,
    input  logic              op_halt,
    input  logic              halt_bug_set,
    input  logic [N-1:0]      irq_req,
    input  logic [N-1:0]      irq_en,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [ADDR_W-1:0] sp_in,
    output logic              mcycle,
    output logic              step_done,
    output logic              fetch_go,
    output logic              fetch_keep_pc,
    output logic              halted,
    output logic              ime,
    output logic [N-1:0]      ack_clear,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              sp_load,
    output logic [ADDR_W-1:0] sp_out,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_out
);
    localparam int IDX_W = idx_width(N);

    logic             any_act;
    logic [IDX_W-1:0] sel_idx;
    logic             svc_clr;

    irq_front_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
        .req (irq_req),
        .en  (irq_en),
        .any (any_act),
        .idx (sel_idx)
    );

    irq_front_ime u_ime (
        .clk        (clk),
        .rst        (rst),
        .instr_done (instr_done),
        .op_ei      (op_ei),
        .op_di      (op_di),
        .op_reti    (op_reti),
        .svc_clr    (svc_clr),
        .ime_on     (ime)
    );

    irq_front_seq #(.N(N), .IDX_W(IDX_W)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .step          (step),
        .halt_set      (instr_done & op_halt),
        .bug_set       (halt_bug_set),
        .active_any    (any_act),
        .pick_idx      (sel_idx),
        .ime_on        (ime),
        .pc_in         (pc_in),
        .sp_in         (sp_in),
        .svc_clr       (svc_clr),
        .mcycle        (mcycle),
        .step_done     (step_done),
        .fetch_go      (fetch_go),
        .fetch_keep_pc (fetch_keep_pc),
        .halted        (halted),
        .ack_clear     (ack_clear),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .sp_load       (sp_load),
        .sp_out        (sp_out),
        .pc_load       (pc_load),
        .pc_out        (pc_out)
    );
endmodule

// File: rtl/irq_front_chk.sv
module irq_front_chk
    import irq_front_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input logic              clk,
    input logic              rst,
    input logic              instr_done,
    input logic              ime,
    input logic              halted,
    input logic              fetch_go,
    input logic              mcycle,
    input logic              step_done,
    input logic [N-1:0]      ack_clear,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              pc_load
);
    // R4: at most one request bit acknowledged at a time
    a_r4_ack_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_clear));

    // R4: the acknowledge cycle sees the enable already dropped
    a_r4_ack_ime_low: assert property (@(posedge clk) disable iff (rst)
        (|ack_clear) |-> !ime);

    // R5: low byte goes one address below the high byte, in the next cycle
    a_r5_lo_follows_hi: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we) |=> (mem_we && (mem_addr == $past(mem_addr) - addr_t'(1))));

    // R6: handler load comes right after the last push write
    a_r6_pc_after_push: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> (!mem_we && $past(mem_we)));

    // R2: no fetch is granted while still halted
    a_r2_fetch_awake: assert property (@(posedge clk) disable iff (rst)
        fetch_go |-> !halted);

    // R2: every finished step either spent a cycle or granted a fetch
    a_r2_done_kind: assert property (@(posedge clk) disable iff (rst)
        step_done |-> (mcycle || fetch_go));

    // R10: the enable only rises as a result of a completed instruction
    a_r10_ime_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(ime) |-> $past(instr_done));
endmodule

bind irq_front irq_front_chk #(.N(N)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .instr_done (instr_done),
    .ime        (ime),
    .halted     (halted),
    .fetch_go   (fetch_go),
    .mcycle     (mcycle),
    .step_done  (step_done),
    .ack_clear  (ack_clear),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .pc_load    (pc_load)
);

// File: tb/irq_front_test.sv
`timescale 1ns/1ps
module irq_front_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic step = 0, instr_done = 0, op_ei = 0, op_di = 0, op_reti = 0, op_halt = 0, halt_bug_set = 0;
    logic [4:0]  irq_req = 0, irq_en = 0;
    logic [15:0] pc_in = 0, sp_in = 0;
    logic mcycle, step_done, fetch_go, fetch_keep_pc, halted, ime;
    logic [4:0] ack_clear;
    logic mem_we, sp_load, pc_load;
    logic [15:0] mem_addr, sp_out, pc_out;
    logic [7:0] mem_wdata;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    irq_front uut (
        .clk(clk), .rst(rst), .step(step), .instr_done(instr_done),
        .op_ei(op_ei), .op_di(op_di), .op_reti(op_reti), .op_halt(op_halt),
        .halt_bug_set(halt_bug_set), .irq_req(irq_req), .irq_en(irq_en),
        .pc_in(pc_in), .sp_in(sp_in), .mcycle(mcycle), .step_done(step_done),
        .fetch_go(fetch_go), .fetch_keep_pc(fetch_keep_pc), .halted(halted),
        .ime(ime), .ack_clear(ack_clear), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .sp_load(sp_load), .sp_out(sp_out),
        .pc_load(pc_load), .pc_out(pc_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_step();
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
    endtask

    task automatic instr(input bit ei, input bit di, input bit reti, input bit hlt);
        op_ei = ei; op_di = di; op_reti = reti; op_halt = hlt; instr_done = 1'b1;
        @(negedge clk);
        op_ei = 0; op_di = 0; op_reti = 0; op_halt = 0; instr_done = 1'b0;
    endtask

    task automatic arm_bug();
        halt_bug_set = 1'b1;
        @(negedge clk);
        halt_bug_set = 1'b0;
    endtask

    function automatic int lowest(input logic [4:0] a);
        int k = -1;
        for (int i = 4; i >= 0; i--) if (a[i]) k = i;
        return k;
    endfunction

    task automatic do_svc(input logic [4:0] rq, input logic [4:0] en,
                          input logic [15:0] pc, input logic [15:0] sp, input bit bug);
        int k;
        logic [15:0] ret;
        k = lowest(rq & en);
        ret = bug ? pc - 16'd1 : pc;
        irq_req = rq; irq_en = en; pc_in = pc; sp_in = sp;
        do_step();
        chk("R4 wait1 mcycle/we/ack", {mcycle, mem_we, ack_clear}, {1'b1, 1'b0, 5'd0});
        @(negedge clk);
        chk("R4 wait2 mcycle/we/ack", {mcycle, mem_we, ack_clear}, {1'b1, 1'b0, 5'd0});
        @(negedge clk);
        chk("R4 ack one-hot", ack_clear, 32'(5'd1 << k));
        chk("R4 ime cleared", ime, 0);
        chk("R5 hi write", {mem_we, sp_load, mem_addr, sp_out, mem_wdata},
            {1'b1, 1'b1, sp - 16'd1, sp - 16'd1, ret[15:8]});
        @(negedge clk);
        chk(bug ? "R8 lo write" : "R5 lo write", {mem_we, mem_addr, sp_out, mem_wdata},
            {1'b1, sp - 16'd2, sp - 16'd2, ret[7:0]});
        @(negedge clk);
        chk("R6 handler load", {mcycle, mem_we, pc_load, step_done, pc_out},
            {1'b1, 1'b0, 1'b1, 1'b1, 16'h0040 + 16'(8 * k)});
        chk("R7 serviced source", 32'(k), 32'(lowest(rq & en)));
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset state",
            {halted, ime, mcycle, step_done, fetch_go, mem_we, pc_load, ack_clear},
            12'd0);

        // R2: halted, nothing active (request present but masked: R7)
        instr(0, 0, 0, 1);
        chk("R2 halted set", halted, 1);
        irq_req = 5'b00100; irq_en = 5'b00011;
        do_step();
        chk("R2 idle cycle", {mcycle, step_done, fetch_go, halted}, 4'b1101);
        chk("R7 masked request ignored for wake", halted, 1);
        @(negedge clk);
        chk("R2 back to idle", {mcycle, step_done}, 2'b00);

        // R3: wake with ime off -> fetch
        irq_en = 5'b00100;
        do_step();
        chk("R3 wake to fetch", {fetch_go, step_done, halted, mcycle}, 4'b1100);
        @(negedge clk);

        // R3 + R4: wake with ime on -> dispatch
        instr(0, 0, 1, 0);
        instr(0, 0, 0, 1);
        do_svc(5'b00100, 5'b11111, 16'h2000, 16'hD000, 0);
        chk("R3 wake before dispatch", halted, 0);

        // Sweeps over request and enable patterns
        for (int r = 1; r < 32; r++) begin
            instr(0, 0, 1, 0);
            do_svc(5'(r), 5'h1F, 16'h1234 + 16'(r * 77), 16'hC000 + 16'(r * 3), 0);
        end
        for (int e = 1; e < 32; e++) begin
            instr(0, 0, 1, 0);
            do_svc(5'h1F, 5'(e), 16'h8000 - 16'(e), 16'hFF80 - 16'(e), 0);
        end
        // R5: stack wrap
        instr(0, 0, 1, 0);
        do_svc(5'b10000, 5'b10000, 16'hABCD, 16'h0000, 0);

        // R8: halt bug on entry, then cleared
        instr(0, 0, 1, 0);
        arm_bug();
        do_svc(5'b00010, 5'h1F, 16'h4000, 16'hE000, 1);
        instr(0, 0, 1, 0);
        do_svc(5'b00010, 5'h1F, 16'h4000, 16'hE000, 0);

        // R9: halt bug on fetch
        instr(0, 1, 0, 0);
        irq_req = 0;
        arm_bug();
        do_step();
        chk("R9 keep pc once", {fetch_go, fetch_keep_pc}, 2'b11);
        @(negedge clk);
        do_step();
        chk("R9 flag cleared", {fetch_go, fetch_keep_pc}, 2'b10);
        @(negedge clk);

        // R10: delayed enable
        chk("R11 ime off after di", ime, 0);
        instr(1, 0, 0, 0);
        chk("R10 ime still off after ei", ime, 0);
        irq_req = 5'b00001; irq_en = 5'b00001;
        do_step();
        chk("R10 no entry while armed", {fetch_go, mcycle}, 2'b10);
        @(negedge clk);
        instr(0, 0, 0, 0);
        chk("R10 ime on after next instr", ime, 1);
        instr(1, 0, 0, 0);
        chk("R10 ei while on keeps on", ime, 1);
        instr(0, 1, 0, 0);
        chk("R11 di clears", ime, 0);
        instr(1, 0, 0, 0);
        instr(0, 1, 0, 0);
        chk("R11 di cancels armed", ime, 0);
        instr(0, 0, 0, 0);
        chk("R11 stays off", ime, 0);
        instr(0, 0, 1, 0);
        chk("R11 reti enables", ime, 1);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule